// File: doc/BRIEF.md
# Per-Source Interrupt Rate Monitor

This block measures how often each interrupt source fires. Every interrupt entry shows up as a one-cycle event strobe with the index of the source. A counter for that source counts the event. A free-running timebase, made from a 1 ms tick input, closes a measurement window after a set number of ticks. At the close of a window, all live counts are copied into a snapshot bank and the live counters start again from zero. Software reads the snapshot bank to get the event rate of each source over the last window.

A storm detector watches each event as it arrives. It compares the live count of that source against a programmable threshold, using the count from before the increment. When the count is already above the threshold, the detector sets a sticky alarm and latches the source index. The detector is a two-state machine:
- **QUIET**: no alarm. A detector hit moves it to STORM and captures the index (transition *trip*).
- **STORM**: the alarm is raised. A clear without a hit returns it to QUIET (transition *release*). A clear in the same cycle as a hit keeps it in STORM with the new index (transition *retrip*). With no clear it holds (transition *hold*).

Threshold and window length are writable registers that reset to parameter defaults. The read port is combinational.

Top module: `irq_rate_mon`

## Requirements
- R1: After reset, all snapshots read zero, the alarm is low, the offending index is zero, the threshold register reads DEF_THRESH and the window register reads DEF_WINDOW.
- R2: Each event strobe with index i adds one to the live count of source i only. After the window closes, reading address 16+i returns that count, zero-extended.
- R3: The tick counter starts at zero and resets to zero on a tick that finds it at or above the window length. A window therefore closes on tick number WINDOW+1, counted from reset or from the previous close. Snapshots change only in that tick's cycle and are readable right after that clock edge.
- R4: When a window closes, every live count is cleared. Events from the closed window do not appear in the next snapshot.
- R5: An event in the same cycle as a window close counts as the first event of the new window. It never raises the alarm.
- R6: A live count saturates at 2^CNT_W-1 instead of wrapping.
- R7: An event whose source's live count, taken before the increment, is strictly greater than the threshold raises the alarm. It also sets the offending index to that source, one clock edge later. With threshold T, the (T+2)-th event of a window is the first one that trips.
- R8: While the alarm is set, later hits from any source do not change the latched index.
- R9: A write to address 0 with bit 0 set clears the alarm and sets the index to zero. A write with bit 0 clear has no effect.
- R10: Address 1 holds the threshold and address 2 holds the window length, both readable and writable. Reading address 0 gives the alarm in bit 0 and the offending index in bits starting at bit 8. Other addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle 1 ms timebase pulse |
| evt_valid | input | 1 | Interrupt-entry event strobe |
| evt_src | input | SRC_W | Source index of the event |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | DATA_W | Combinational read data |
| storm_alarm | output | 1 | Sticky storm alarm |
| storm_src | output | SRC_W | Index of the source that tripped the alarm |

## Verification
Results appear with different delays:
- Counts, snapshots, alarm and index are registered one edge after the cycle that causes them. The closing tick updates the snapshots at its own edge.
- Register writes take effect at the write edge.
- Reads are combinational.

The bench drives each stimulus for exactly one cycle from the falling edge and advances its model at the rising edge. It samples ports and read data at the next falling edge, so each expected value is compared in the first cycle where it is due. Directed sequences place events exactly on the closing tick, on the (T+1)-th and (T+2)-th event, and past saturation.

// File: rtl/irqmon_pkg.sv
`timescale 1ns/1ps
package irqmon_pkg;

    typedef enum logic [0:0] {
        AL_QUIET = 1'b0,
        AL_STORM = 1'b1
    } alarm_state_e;

    // register address map
    localparam int REG_CTRL       = 0;   // write: bit0 clears alarm; read: status
    localparam int REG_THRESH     = 1;
    localparam int REG_WINDOW     = 2;
    localparam int SNAP_BASE      = 16;  // snapshot of source i at SNAP_BASE+i
    localparam int CLR_BIT        = 0;
    localparam int STATUS_SRC_LSB = 8;

endpackage

// File: rtl/irqmon_window.sv
`timescale 1ns/1ps
module irqmon_window #(
    parameter int WIN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [WIN_W-1:0] win_len,
    output logic             roll
);

    logic [WIN_W-1:0] tcnt_q;

    // close the window on a tick that finds the count at or above the length
    assign roll = tick && (tcnt_q >= win_len);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt_q <= '0;
        end else if (tick) begin
            if (roll) tcnt_q <= '0;
            else      tcnt_q <= tcnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/irqmon_counters.sv
`timescale 1ns/1ps
module irqmon_counters #(
    parameter int NUM_SRC = 8,
    parameter int CNT_W   = 20,
    parameter int SRC_W   = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     evt_valid,
    input  logic [SRC_W-1:0]         evt_src,
    input  logic                     roll,
    output logic [NUM_SRC*CNT_W-1:0] live_flat,
    output logic [NUM_SRC*CNT_W-1:0] snap_flat
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        logic             match;
        logic [CNT_W-1:0] live_q;
        logic [CNT_W-1:0] snap_q;

        assign match = evt_valid && (evt_src == SRC_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                live_q <= '0;
                snap_q <= '0;
            end else if (roll) begin
                snap_q <= live_q;
                live_q <= match ? CNT_W'(1) : '0;
            end else if (match && (live_q != CNT_MAX)) begin
                live_q <= live_q + 1'b1;
            end
        end

        assign live_flat[i*CNT_W +: CNT_W] = live_q;
        assign snap_flat[i*CNT_W +: CNT_W] = snap_q;
    end

endmodule

// File: rtl/irqmon_alarm.sv
`timescale 1ns/1ps
module irqmon_alarm
    import irqmon_pkg::*;
#(
    parameter int CNT_W = 20,
    parameter int SRC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_valid,
    input  logic [SRC_W-1:0] evt_src,
    input  logic             roll,
    input  logic [CNT_W-1:0] live_sel,
    input  logic [CNT_W-1:0] threshold,
    input  logic             clr,
    output logic             hit,
    output logic             alarm,
    output logic [SRC_W-1:0] alarm_src
);

    alarm_state_e     state_q, state_d;
    logic [SRC_W-1:0] src_q, src_d;

    // pre-increment compare; an event on a closing tick belongs to a fresh window
    assign hit = evt_valid && !roll && (live_sel > threshold);

    always_comb begin
        state_d = state_q;
        src_d   = src_q;
        unique case (state_q)
            AL_QUIET: begin
                if (hit) begin
                    state_d = AL_STORM;
                    src_d   = evt_src;
                end
            end
            AL_STORM: begin
                if (clr) begin
                    if (hit) begin
                        state_d = AL_STORM;
                        src_d   = evt_src;
                    end else begin
                        state_d = AL_QUIET;
                        src_d   = '0;
                    end
                end
            end
            default: begin
                state_d = AL_QUIET;
                src_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= AL_QUIET;
            src_q   <= '0;
        end else begin
            state_q <= state_d;
            src_q   <= src_d;
        end
    end

    always_comb begin
        alarm     = (state_q == AL_STORM);
        alarm_src = src_q;
    end

endmodule

// File: rtl/irq_rate_mon.sv
`timescale 1ns/1ps
module irq_rate_mon
    import irqmon_pkg::*;
#(
    parameter int NUM_SRC    = 8,
    parameter int CNT_W      = 20,
    parameter int WIN_W      = 16,
    parameter int DATA_W     = 32,
    parameter int DEF_THRESH = 100000,
    parameter int DEF_WINDOW = 1000,
    localparam int SRC_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int ADDR_W    = $clog2(SNAP_BASE + NUM_SRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              evt_valid,
    input  logic [SRC_W-1:0]  evt_src,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              storm_alarm,
    output logic [SRC_W-1:0]  storm_src
);

    logic [CNT_W-1:0]         thresh_q;
    logic [WIN_W-1:0]         win_q;
    logic                     roll;
    logic                     alarm_clr;
    logic                     storm_hit;
    logic [CNT_W-1:0]         live_sel;
    logic [NUM_SRC*CNT_W-1:0] live_flat;
    logic [NUM_SRC*CNT_W-1:0] snap_flat;

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thresh_q <= CNT_W'(DEF_THRESH);
            win_q    <= WIN_W'(DEF_WINDOW);
        end else if (wr_en) begin
            if (wr_addr == ADDR_W'(REG_THRESH)) thresh_q <= wr_data[CNT_W-1:0];
            if (wr_addr == ADDR_W'(REG_WINDOW)) win_q    <= wr_data[WIN_W-1:0];
        end
    end

    assign alarm_clr = wr_en && (wr_addr == ADDR_W'(REG_CTRL)) && wr_data[CLR_BIT];

    irqmon_window #(
        .WIN_W (WIN_W)
    ) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .win_len (win_q),
        .roll    (roll)
    );

    irqmon_counters #(
        .NUM_SRC (NUM_SRC),
        .CNT_W   (CNT_W),
        .SRC_W   (SRC_W)
    ) u_counters (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_valid (evt_valid),
        .evt_src   (evt_src),
        .roll      (roll),
        .live_flat (live_flat),
        .snap_flat (snap_flat)
    );

    // live count of the source named by the current event
    always_comb begin
        live_sel = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (evt_src == SRC_W'(i)) live_sel = live_flat[i*CNT_W +: CNT_W];
        end
    end

    irqmon_alarm #(
        .CNT_W (CNT_W),
        .SRC_W (SRC_W)
    ) u_alarm (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_valid (evt_valid),
        .evt_src   (evt_src),
        .roll      (roll),
        .live_sel  (live_sel),
        .threshold (thresh_q),
        .clr       (alarm_clr),
        .hit       (storm_hit),
        .alarm     (storm_alarm),
        .alarm_src (storm_src)
    );

    // combinational read port
    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(REG_CTRL)) begin
            rd_data[CLR_BIT]                    = storm_alarm;
            rd_data[STATUS_SRC_LSB +: SRC_W]    = storm_src;
        end else if (rd_addr == ADDR_W'(REG_THRESH)) begin
            rd_data = DATA_W'(thresh_q);
        end else if (rd_addr == ADDR_W'(REG_WINDOW)) begin
            rd_data = DATA_W'(win_q);
        end else begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (rd_addr == ADDR_W'(SNAP_BASE + i))
                    rd_data = DATA_W'(snap_flat[i*CNT_W +: CNT_W]);
            end
        end
    end

endmodule

// File: rtl/irqmon_chk.sv
`timescale 1ns/1ps
module irqmon_chk #(
    parameter int NUM_SRC = 8,
    parameter int CNT_W   = 20,
    parameter int SRC_W   = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     evt_valid,
    input logic                     roll,
    input logic                     clr,
    input logic                     hit,
    input logic                     storm_alarm,
    input logic [SRC_W-1:0]         storm_src,
    input logic [NUM_SRC*CNT_W-1:0] live_flat
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_live
        // R4: a window close leaves at most the coinciding event in each counter
        a_r4_live_cleared: assert property (@(posedge clk) disable iff (!rst_n)
            roll |=> (live_flat[i*CNT_W +: CNT_W] <= CNT_W'(1)));

        // R6: a full counter stays full until the window closes
        a_r6_saturate_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (live_flat[i*CNT_W +: CNT_W] == CNT_MAX) && !roll
            |=> (live_flat[i*CNT_W +: CNT_W] == CNT_MAX));
    end

    // R5: the closing cycle never trips the alarm
    a_r5_no_trip_on_close: assert property (@(posedge clk) disable iff (!rst_n)
        roll |=> !$rose(storm_alarm));

    // R7: the alarm only rises after an event
    a_r7_rise_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(storm_alarm) |-> $past(evt_valid));

    // R8: latched alarm and index hold without a clear
    a_r8_index_held: assert property (@(posedge clk) disable iff (!rst_n)
        storm_alarm && !clr |=> storm_alarm && $stable(storm_src));

    // R9: a clear with no concurrent hit drops the alarm
    a_r9_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        clr && !hit |=> !storm_alarm && (storm_src == '0));

endmodule

bind irq_rate_mon irqmon_chk #(
    .NUM_SRC (NUM_SRC),
    .CNT_W   (CNT_W),
    .SRC_W   (SRC_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_valid   (evt_valid),
    .roll        (roll),
    .clr         (alarm_clr),
    .hit         (storm_hit),
    .storm_alarm (storm_alarm),
    .storm_src   (storm_src),
    .live_flat   (live_flat)
);

// File: tb/irq_rate_mon_tb.sv
`timescale 1ns/1ps
module irq_rate_mon_tb;

    localparam int NS   = 8;
    localparam int CW   = 8;
    localparam int WW   = 10;
    localparam int DW   = 32;
    localparam int DTH  = 200;
    localparam int DWIN = 1000;
    localparam int SW   = 3;
    localparam int AW   = 5;
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          evt_valid = 1'b0;
    logic [SW-1:0] evt_src = '0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          storm_alarm;
    logic [SW-1:0] storm_src;

    irq_rate_mon #(
        .NUM_SRC (NS), .CNT_W (CW), .WIN_W (WW), .DATA_W (DW),
        .DEF_THRESH (DTH), .DEF_WINDOW (DWIN)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .tick (tick),
        .evt_valid (evt_valid), .evt_src (evt_src),
        .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
        .rd_addr (rd_addr), .rd_data (rd_data),
        .storm_alarm (storm_alarm), .storm_src (storm_src)
    );

    always #10 clk = ~clk;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    // bench model
    int  m_live [NS];
    int  m_snap [NS];
    int  m_tcnt, m_thr, m_win, m_src;
    bit  m_al, m_roll;

    task automatic chk(input string tag, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fails++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    function automatic int status_word(input bit al, input int src);
        return (src << 8) | int'(al);
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NS; i++) begin m_live[i] = 0; m_snap[i] = 0; end
        m_tcnt = 0; m_thr = DTH; m_win = DWIN; m_al = 0; m_src = 0; m_roll = 0;
    endtask

    task automatic model_step(input bit t, input bit e, input int s);
        bit hit;
        m_roll = t && (m_tcnt >= m_win);
        hit = e && !m_roll && (m_live[s] > m_thr);
        if (t) m_tcnt = m_roll ? 0 : m_tcnt + 1;
        if (m_roll) begin
            for (int i = 0; i < NS; i++) begin m_snap[i] = m_live[i]; m_live[i] = 0; end
            if (e) m_live[s] = 1;
        end else if (e && m_live[s] < CMAX) begin
            m_live[s]++;
        end
        if (hit && !m_al) begin m_al = 1; m_src = s; end
    endtask

    task automatic cycle(input bit t, input bit e, input int s);
        tick = t; evt_valid = e; evt_src = SW'(s);
        @(posedge clk);
        model_step(t, e, s);
        @(negedge clk);
        tick = 0; evt_valid = 0;
    endtask

    task automatic wr(input int a, input int d);
        wr_en = 1; wr_addr = AW'(a); wr_data = DW'(d);
        @(posedge clk);
        if (a == 1) m_thr = d & CMAX;
        if (a == 2) m_win = d & ((1 << WW) - 1);
        if (a == 0 && d[0]) begin m_al = 0; m_src = 0; end
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd_chk(input string tag, input int a, input int exp);
        rd_addr = AW'(a);
        #1;
        chk(tag, int'(rd_data), exp);
    endtask

    task automatic run_to_close();
        while (m_tcnt < m_win) cycle(1, 0, 0);
    endtask

    task automatic do_reset();
        rst_n = 0; tick = 0; evt_valid = 0; wr_en = 0;
        repeat (3) @(negedge clk);
        model_reset();
        rst_n = 1;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();

        // R1 reset state
        rd_chk("R1 status", 0, 0);
        rd_chk("R1 threshold", 1, DTH);
        rd_chk("R1 window", 2, DWIN);
        for (int i = 0; i < NS; i++) rd_chk("R1 snapshot", 16 + i, 0);
        chk("R1 alarm port", int'(storm_alarm), 0);
        rd_chk("R10 unmapped", 5, 0);

        // R3 window length: one event, then WINDOW ticks, then the closing tick
        cycle(0, 1, 2);
        repeat (DWIN) cycle(1, 0, 0);
        rd_chk("R3 no close after WINDOW ticks", 18, 0);
        cycle(1, 0, 0);
        rd_chk("R3 closes on tick WINDOW+1", 18, 1);

        // R4 live counters cleared at close
        wr(2, 3);
        rd_chk("R10 window readback", 2, 3);
        repeat (4) cycle(1, 0, 0);
        rd_chk("R4 old events gone", 18, 0);

        // R5 event on the closing tick goes to the new window
        wr(2, DWIN);
        cycle(0, 1, 5); cycle(0, 1, 5);
        run_to_close();
        cycle(1, 1, 5);
        rd_chk("R5 closed window count", 21, 2);
        run_to_close();
        cycle(1, 0, 0);
        rd_chk("R5 coinciding event in next window", 21, 1);

        // R6 saturation
        wr(1, CMAX);
        rd_chk("R10 threshold readback", 1, CMAX);
        repeat (300) cycle(0, 1, 1);
        run_to_close();
        cycle(1, 0, 0);
        rd_chk("R6 saturated snapshot", 17, CMAX);
        chk("R6 saturated count never trips", int'(storm_alarm), 0);

        // R7 trip on the (T+2)-th event
        wr(1, 3);
        repeat (4) cycle(0, 1, 6);
        chk("R7 no alarm at T+1 events", int'(storm_alarm), 0);
        cycle(0, 1, 6);
        chk("R7 alarm at T+2 events", int'(storm_alarm), 1);
        chk("R7 offending index", int'(storm_src), 6);

        // R8 index held
        repeat (5) cycle(0, 1, 4);
        chk("R8 index held", int'(storm_src), 6);
        rd_chk("R10 status word", 0, status_word(1, 6));

        // R9 clear semantics
        wr(0, 0);
        chk("R9 write 0 no effect", int'(storm_alarm), 1);
        wr(0, 1);
        chk("R9 clear drops alarm", int'(storm_alarm), 0);
        rd_chk("R9 status cleared", 0, 0);

        // R5 an event on the close above threshold does not trip
        repeat (4) cycle(0, 1, 3);
        run_to_close();
        cycle(1, 1, 3);
        chk("R5 no trip on closing tick", int'(storm_alarm), 0);
        rd_chk("R5 snapshot src3", 19, 4);
        rd_chk("R2 snapshot src6", 22, 5);

        // constrained random mix, R2/R7/R8/R9 against the model
        wr(2, 20);
        wr(1, 5);
        for (int n = 0; n < 1500; n++) begin
            if ($urandom_range(0, 49) == 0) begin
                wr(0, 1);
            end else begin
                cycle(($urandom_range(0, 2) == 0), ($urandom_range(0, 1) == 1),
                      int'($urandom_range(0, NS - 1)));
            end
            chk("R7 random alarm", int'(storm_alarm), int'(m_al));
            chk("R8 random index", int'(storm_src), m_src);
            if (m_roll) begin
                for (int i = 0; i < NS; i++) rd_chk("R2 random snapshot", 16 + i, m_snap[i]);
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule